// File: doc/BRIEF.md
# Multi-Rail Power-Good Supervisor

This block supervises five regulator rails (four switching regulators and one linear regulator) and produces one power-good level for the rest of the chip, typically the reset input of a processor. Each rail provides a sampled voltage code, a target code and an enable bit. Per rail, the block compares the measured code against percentages of the target, filters each raw result through asymmetric time-qualification counters, and then combines the filtered results of the enabled rails into the output.

A mode input picks one of two supervision styles. Relaxed mode checks only for a low voltage, with a loose limit and a long qualification time. Strict mode checks both low and high voltage, with tight limits that differ between rails 0–1 and rails 2–4, and with a shorter qualification time for a low voltage. All qualification times are tick counts derived from a clock-frequency parameter. Percentages are held as per-mille integers and compared as `code*1000` against `target*limit`, so no divider is needed.

Top module: `pg_supervisor`

## Requirements
- R1: `pwr_ok` is 1 only when no enabled rail holds a confirmed fault; it is 0 as soon as any enabled rail holds one.
- R2: A rail whose `rail_en` bit is 0 never pulls `pwr_ok` low, whatever its codes; when it is enabled again it starts in the fault state and must requalify.
- R3: With `strict_mode` = 0, a rail is low when `code*1000 < target*900` for every rail, and no high-voltage check is made.
- R4: With `strict_mode` = 1, a rail is low when `code*1000 < target*965` for rails 0–1 and `code*1000 < target*955` for rails 2–4.
- R5: With `strict_mode` = 1, a rail is high when `code*1000 > target*1035` for rails 0–1 and `code*1000 > target*1045` for rails 2–4.
- R6: A low-voltage fault is confirmed after CLK_HZ/1000 consecutive clock cycles in relaxed mode and CLK_HZ/20000 in strict mode.
- R7: A low-voltage fault is cleared after CLK_HZ/100000 consecutive in-range cycles in either mode.
- R8: A high-voltage fault is confirmed after CLK_HZ/20000 consecutive cycles and cleared after CLK_HZ/1000 consecutive in-range cycles.
- R9: A raw condition that returns to the current filtered state for even one cycle restarts its qualification count from zero.
- R10: A change of `strict_mode` clears every qualification count on the following clock edge while each rail keeps its filtered state.
- R11: While and after `rst_n` is low, every rail is in the low-voltage fault state, so `pwr_ok` is 0 with any rail enabled until that rail requalifies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, tick source for all qualification times |
| rst_n | input | 1 | Synchronous reset, active low |
| strict_mode | input | 1 | 0 = relaxed (low check only), 1 = strict (low and high) |
| rail_en | input | NUM_RAILS | Per-rail enable; bit i covers rail i |
| rail_code | input | NUM_RAILS x CODE_W | Sampled voltage code of each rail |
| rail_target | input | NUM_RAILS x CODE_W | Target voltage code of each rail |
| pwr_ok | output | 1 | 1 = every enabled rail in tolerance, 0 = fault present |

## Verification
A vector table steps one rail at a time to codes just inside and just outside each limit, in both modes and for both rail groups, which separates the 965/955 and 1035/1045 groups from each other and from the relaxed 900 limit, and shows that high codes pass in relaxed mode. Directed sequences then hold a fault for one cycle less and exactly the qualification count, in each mode and direction, which tells the four different counts apart. A one-cycle bounce, a mode switch in mid-count and a mode switch on a confirmed fault distinguish a restarted count from a paused one and a cleared count from a cleared state. Disabling, re-enabling and a reset mid-run show the fault start state.

// File: rtl/pg_pkg.sv
// Package: shared constants and types of the power-good supervisor.
// Limits are per-mille of the target code; 1000 is the scale factor.
package pg_pkg;
    localparam int unsigned PM_SCALE    = 1000;
    localparam int unsigned UV_RELAX    = 900;
    localparam int unsigned UV_STRICT_A = 965;
    localparam int unsigned UV_STRICT_B = 955;
    localparam int unsigned OV_STRICT_A = 1035;
    localparam int unsigned OV_STRICT_B = 1045;
    localparam int unsigned PM_W        = 11;

    typedef enum logic {
        MODE_RELAXED = 1'b0,
        MODE_STRICT  = 1'b1
    } pg_mode_e;
endpackage

// File: rtl/pg_thresh_cmp.sv
// Module: pg_thresh_cmp
// Compares one rail's code against per-mille fractions of its target.
// Assumes code and target are unsigned; group A selects the tighter
// strict-mode limits. The high check is suppressed in relaxed mode.
module pg_thresh_cmp
    import pg_pkg::*;
#(
    parameter int unsigned CODE_W  = 12,
    parameter bit          GROUP_A = 1'b1
) (
    input  logic              strict,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] target,
    output logic              raw_uv,
    output logic              raw_ov
);
    localparam int unsigned PROD_W = CODE_W + PM_W;

    logic [PM_W-1:0]   uv_pm;
    logic [PM_W-1:0]   ov_pm;
    logic [PROD_W-1:0] meas_scaled;
    logic [PROD_W-1:0] uv_lim;
    logic [PROD_W-1:0] ov_lim;

    // Pick the per-mille limits for the current mode and rail group.
    always_comb begin
        if (pg_mode_e'(strict) == MODE_STRICT) begin
            uv_pm = GROUP_A ? PM_W'(UV_STRICT_A) : PM_W'(UV_STRICT_B);
        end else begin
            uv_pm = PM_W'(UV_RELAX);
        end
        ov_pm = GROUP_A ? PM_W'(OV_STRICT_A) : PM_W'(OV_STRICT_B);
    end

    // Scale both sides so the compare needs no division.
    always_comb begin
        meas_scaled = PROD_W'(code) * PROD_W'(PM_SCALE);
        uv_lim      = PROD_W'(target) * PROD_W'(uv_pm);
        ov_lim      = PROD_W'(target) * PROD_W'(ov_pm);
    end

    // Raw out-of-range flags, before any time qualification.
    always_comb begin
        raw_uv = (meas_scaled < uv_lim);
        raw_ov = strict && (meas_scaled > ov_lim);
    end
endmodule

// File: rtl/pg_deglitch.sv
// Module: pg_deglitch
// Time-qualifies one raw flag. The filtered state follows the raw flag
// only after the raw flag has differed from it for a full count of
// consecutive cycles; the count depends on mode and on direction.
// Assumes every count parameter is at least 1. A disabled rail is held
// at RESET_VAL, the same state as after reset.
module pg_deglitch #(
    parameter int unsigned SET_RELAX  = 1,
    parameter int unsigned SET_STRICT = 1,
    parameter int unsigned CLR_RELAX  = 1,
    parameter int unsigned CLR_STRICT = 1,
    parameter bit          RESET_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_on,
    input  logic strict,
    input  logic mode_chg,
    input  logic raw,
    output logic flt
);
    localparam int unsigned MAX_SET = (SET_RELAX > SET_STRICT) ? SET_RELAX : SET_STRICT;
    localparam int unsigned MAX_CLR = (CLR_RELAX > CLR_STRICT) ? CLR_RELAX : CLR_STRICT;
    localparam int unsigned MAX_LIM = (MAX_SET > MAX_CLR) ? MAX_SET : MAX_CLR;
    localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_m1;

    // Last count value before a flip, chosen by direction and mode.
    always_comb begin
        case ({flt, strict})
            2'b00:   lim_m1 = CNT_W'(SET_RELAX - 1);
            2'b01:   lim_m1 = CNT_W'(SET_STRICT - 1);
            2'b10:   lim_m1 = CNT_W'(CLR_RELAX - 1);
            default: lim_m1 = CNT_W'(CLR_STRICT - 1);
        endcase
    end

    // Count consecutive mismatch cycles and flip the state at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !rail_on) begin
            cnt <= '0;
            flt <= RESET_VAL;
        end else if (mode_chg || (raw == flt)) begin
            cnt <= '0;
        end else if (cnt >= lim_m1) begin
            cnt <= '0;
            flt <= raw;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pg_rail_merge.sv
// Module: pg_rail_merge
// Combines filtered per-rail states into the power-good level.
// Assumes the high-voltage state only counts in strict mode.
module pg_rail_merge #(
    parameter int unsigned NUM_RAILS = 5
) (
    input  logic                 strict,
    input  logic [NUM_RAILS-1:0] rail_en,
    input  logic [NUM_RAILS-1:0] uv_flt,
    input  logic [NUM_RAILS-1:0] ov_flt,
    output logic                 pwr_ok
);
    logic [NUM_RAILS-1:0] rail_bad;

    // A rail is bad only if enabled and in a counted fault.
    always_comb begin
        rail_bad = rail_en & (uv_flt | (strict ? ov_flt : '0));
        pwr_ok   = ~|rail_bad;
    end
endmodule

// File: rtl/pg_supervisor.sv
// Module: pg_supervisor (top)
// Multi-rail power-good supervisor: per-rail threshold compare, per-rail
// low and high qualification filters, and a merge into one level.
// Assumes inputs are synchronous to clk. CLK_HZ sets every tick count.
module pg_supervisor #(
    parameter int unsigned          CLK_HZ       = 200_000_000,
    parameter int unsigned          NUM_RAILS    = 5,
    parameter int unsigned          CODE_W       = 12,
    parameter logic [NUM_RAILS-1:0] GROUP_A_MASK = 5'b00011
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             strict_mode,
    input  logic [NUM_RAILS-1:0]             rail_en,
    input  logic [NUM_RAILS-1:0][CODE_W-1:0] rail_code,
    input  logic [NUM_RAILS-1:0][CODE_W-1:0] rail_target,
    output logic                             pwr_ok
);
    localparam int unsigned RAW_1MS   = CLK_HZ / 1000;
    localparam int unsigned RAW_50US  = CLK_HZ / 20000;
    localparam int unsigned RAW_10US  = CLK_HZ / 100000;
    localparam int unsigned T_1MS     = (RAW_1MS  == 0) ? 1 : RAW_1MS;
    localparam int unsigned T_50US    = (RAW_50US == 0) ? 1 : RAW_50US;
    localparam int unsigned T_10US    = (RAW_10US == 0) ? 1 : RAW_10US;

    logic                 mode_q;
    logic                 mode_chg;
    logic [NUM_RAILS-1:0] raw_uv_vec;
    logic [NUM_RAILS-1:0] raw_ov_vec;
    logic [NUM_RAILS-1:0] uv_flt_vec;
    logic [NUM_RAILS-1:0] ov_flt_vec;

    // Remember the mode of the last cycle to spot a mode switch.
    always_ff @(posedge clk) begin
        mode_q <= strict_mode;
    end

    // A switch is flagged only out of reset, so reset never clears counts twice.
    always_comb begin
        mode_chg = rst_n && (strict_mode != mode_q);
    end

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        pg_thresh_cmp #(
            .CODE_W  (CODE_W),
            .GROUP_A (GROUP_A_MASK[g])
        ) u_cmp (
            .strict (strict_mode),
            .code   (rail_code[g]),
            .target (rail_target[g]),
            .raw_uv (raw_uv_vec[g]),
            .raw_ov (raw_ov_vec[g])
        );

        pg_deglitch #(
            .SET_RELAX  (T_1MS),
            .SET_STRICT (T_50US),
            .CLR_RELAX  (T_10US),
            .CLR_STRICT (T_10US),
            .RESET_VAL  (1'b1)
        ) u_uv_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .rail_on  (rail_en[g]),
            .strict   (strict_mode),
            .mode_chg (mode_chg),
            .raw      (raw_uv_vec[g]),
            .flt      (uv_flt_vec[g])
        );

        pg_deglitch #(
            .SET_RELAX  (T_50US),
            .SET_STRICT (T_50US),
            .CLR_RELAX  (T_1MS),
            .CLR_STRICT (T_1MS),
            .RESET_VAL  (1'b0)
        ) u_ov_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .rail_on  (rail_en[g]),
            .strict   (strict_mode),
            .mode_chg (mode_chg),
            .raw      (raw_ov_vec[g]),
            .flt      (ov_flt_vec[g])
        );
    end

    pg_rail_merge #(
        .NUM_RAILS (NUM_RAILS)
    ) u_merge (
        .strict  (strict_mode),
        .rail_en (rail_en),
        .uv_flt  (uv_flt_vec),
        .ov_flt  (ov_flt_vec),
        .pwr_ok  (pwr_ok)
    );
endmodule

// File: rtl/pg_supervisor_chk.sv
// Module: pg_supervisor_chk
// Temporal checks of the supervisor, bound into every instance.
module pg_supervisor_chk #(
    parameter int unsigned NUM_RAILS = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 strict_mode,
    input logic [NUM_RAILS-1:0] rail_en,
    input logic [NUM_RAILS-1:0] raw_uv,
    input logic [NUM_RAILS-1:0] raw_ov,
    input logic                 pwr_ok
);
    AST_ALL_OFF_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en == '0) |-> pwr_ok); // R2

    AST_RESET_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && (rail_en != '0)) |-> !pwr_ok); // R11

    AST_RELAXED_NO_OV: assert property (@(posedge clk) disable iff (!rst_n)
        !strict_mode |-> (raw_ov == '0)); // R3

    AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwr_ok) && $stable(rail_en) && $stable(strict_mode))
        |-> $past(|(rail_en & (raw_uv | raw_ov)))); // R9

    AST_RISE_HAS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwr_ok) && $stable(rail_en) && $stable(strict_mode))
        |-> $past(|(rail_en & ~(raw_uv | raw_ov)))); // R7
endmodule

bind pg_supervisor pg_supervisor_chk #(
    .NUM_RAILS (NUM_RAILS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strict_mode (strict_mode),
    .rail_en     (rail_en),
    .raw_uv      (raw_uv_vec),
    .raw_ov      (raw_ov_vec),
    .pwr_ok      (pwr_ok)
);

// File: tb/pg_supervisor_test.sv
// Bench for pg_supervisor. CLK_HZ = 1 MHz gives counts of
// 1000 (1 ms), 50 (50 us) and 10 (10 us) cycles.
module pg_supervisor_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned N = 5;
    localparam int unsigned W = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 strict_mode = 1'b0;
    logic [N-1:0]         rail_en = '1;
    logic [N-1:0][W-1:0]  rail_code;
    logic [N-1:0][W-1:0]  rail_target;
    logic                 pwr_ok;

    int checks = 0;
    int errors = 0;

    pg_supervisor #(
        .CLK_HZ    (1_000_000),
        .NUM_RAILS (N),
        .CODE_W    (W)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .strict_mode (strict_mode),
        .rail_en     (rail_en),
        .rail_code   (rail_code),
        .rail_target (rail_target),
        .pwr_ok      (pwr_ok)
    );

    always #2.5 clk = ~clk;

    // Vector: {mode, enable mask, rail index, code, expected pwr_ok}
    localparam int NV = 15;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 5'b11111, 3'd0, 12'd890,  1'b0},
        {1'b0, 5'b11111, 3'd0, 12'd900,  1'b1},
        {1'b0, 5'b11111, 3'd4, 12'd899,  1'b0},
        {1'b0, 5'b11111, 3'd2, 12'd1200, 1'b1},
        {1'b1, 5'b11111, 3'd0, 12'd964,  1'b0},
        {1'b1, 5'b11111, 3'd0, 12'd965,  1'b1},
        {1'b1, 5'b11111, 3'd2, 12'd960,  1'b1},
        {1'b1, 5'b11111, 3'd3, 12'd954,  1'b0},
        {1'b1, 5'b11111, 3'd1, 12'd1036, 1'b0},
        {1'b1, 5'b11111, 3'd1, 12'd1035, 1'b1},
        {1'b1, 5'b11111, 3'd4, 12'd1040, 1'b1},
        {1'b1, 5'b11111, 3'd4, 12'd1046, 1'b0},
        {1'b1, 5'b11110, 3'd0, 12'd0,    1'b1},
        {1'b0, 5'b00000, 3'd3, 12'd0,    1'b1},
        {1'b1, 5'b11111, 3'd4, 12'd1000, 1'b1}
    };
    localparam string TAGS [NV] = '{
        "R3 relaxed low", "R3 relaxed at limit", "R3 relaxed rail4 low",
        "R3 relaxed high ignored", "R4 strict A low", "R4 strict A at limit",
        "R4 strict B in range", "R4 strict B low", "R5 strict A high",
        "R5 strict A at limit", "R5 strict B in range", "R5 strict B high",
        "R2 disabled rail", "R2 all disabled", "R1 all nominal"
    };

    task automatic chk(input logic exp, input string tag);
        checks++;
        if (pwr_ok !== exp) begin
            errors++;
            $display("FAIL %s: pwr_ok=%0b expected %0b", tag, pwr_ok, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_code(input int r, input int c);
        @(negedge clk);
        rail_code[r] = W'(c);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        for (int r = 0; r < N; r++) begin
            rail_code[r]   = W'(1000);
            rail_target[r] = W'(1000);
        end
        step(3);
        chk(1'b0, "R11 low during reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk(1'b0, "R11 low after reset");
        step(9);
        chk(1'b0, "R7 clear count minus one");
        step(1);
        chk(1'b1, "R7 clear count reached");

        // Table walk: settle well past the longest count.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            strict_mode = VEC[v][21];
            rail_en     = VEC[v][20:16];
            for (int r = 0; r < N; r++)
                rail_code[r] = (r == int'(VEC[v][15:13])) ? VEC[v][12:1] : W'(1000);
            step(1100);
            chk(VEC[v][0], TAGS[v]);
        end

        // Strict low entry, 50 cycles (R6), clear 10 cycles (R7).
        set_code(0, 900);
        step(49); chk(1'b1, "R6 strict entry minus one");
        step(1);  chk(1'b0, "R6 strict entry reached");
        set_code(0, 1000);
        step(9);  chk(1'b0, "R7 clear minus one");
        step(1);  chk(1'b1, "R7 clear reached");

        // One-cycle bounce restarts the count (R9).
        set_code(0, 900);
        step(49); chk(1'b1, "R9 before bounce");
        set_code(0, 1000);
        set_code(0, 900);
        step(49); chk(1'b1, "R9 count restarted");
        step(1);  chk(1'b0, "R9 full count after bounce");
        set_code(0, 1000);
        step(10); chk(1'b1, "R7 recovered");

        // High voltage: 50 in, 1000 out (R8).
        set_code(2, 1100);
        step(49);  chk(1'b1, "R8 high entry minus one");
        step(1);   chk(1'b0, "R8 high entry reached");
        set_code(2, 1000);
        step(999); chk(1'b0, "R8 high clear minus one");
        step(1);   chk(1'b1, "R8 high clear reached");

        // Relaxed low entry, 1000 cycles (R6).
        @(negedge clk); strict_mode = 1'b0;
        step(5);
        set_code(0, 850);
        step(999); chk(1'b1, "R6 relaxed entry minus one");
        step(1);   chk(1'b0, "R6 relaxed entry reached");
        set_code(0, 1000);
        step(10);  chk(1'b1, "R7 relaxed clear");

        // Mode switch mid-count clears the count (R10).
        @(negedge clk); strict_mode = 1'b1;
        step(5);
        set_code(0, 850);
        step(40); chk(1'b1, "R10 strict partial count");
        @(negedge clk); strict_mode = 1'b0;
        step(1000); chk(1'b1, "R10 count cleared by switch");
        step(1);    chk(1'b0, "R10 relaxed count completes");

        // Mode switch keeps the confirmed state (R10).
        @(negedge clk); strict_mode = 1'b1; rail_code[0] = W'(960);
        step(5);  chk(1'b0, "R10 strict fault held");
        @(negedge clk); strict_mode = 1'b0;
        step(10); chk(1'b0, "R10 state kept over switch");
        step(1);  chk(1'b1, "R10 relaxed clear after switch");

        // Re-enabled rail starts as a fault (R2).
        @(negedge clk); rail_en[3] = 1'b0;
        step(2);  chk(1'b1, "R2 rail off");
        @(negedge clk); rail_en[3] = 1'b1;
        #1 chk(1'b0, "R2 re-enabled starts faulted");
        step(9);  chk(1'b0, "R2 requalify minus one");
        step(1);  chk(1'b1, "R2 requalified");

        // Reset mid-run (R11).
        @(negedge clk); rst_n = 1'b0;
        step(2);  chk(1'b0, "R11 reset mid-run");
        @(negedge clk); rst_n = 1'b1;
        step(9);  chk(1'b0, "R11 post reset minus one");
        step(1);  chk(1'b1, "R11 post reset released");

        finish_run();
    end
endmodule